// File: doc/BRIEF.md
# Hazard-Triggered Register Checkpoint and Resume Controller

This controller guards a processor against bursts of ionising radiation. It compares a sampled radiation level with a programmable trip threshold. When the level reaches that threshold, it asks the processor core to stop. Once the core confirms that it has halted, the controller copies the core's main registers, program counter included, into a dedicated non-volatile store. It writes one word per cycle, register k to address k.

The core then stays halted until the hazard has passed. The hazard counts as passed when an external all-clear input is raised, or when the level falls below a second, lower threshold. That lower threshold gives hysteresis, so a level hovering between the two thresholds keeps the core parked.

On restart, the saved words are read back one per cycle and loaded into the same registers. A single resume strobe then releases the core, which continues from the exact point where it stopped. A checkpoint-valid flag protects the restore path. If the store rejected a write and the flag is clear, the controller raises a fault instead of restoring. If the hazard returns in the middle of a restore, the restore is abandoned and the saved image is kept for a later attempt.

Top module: `rad_ckpt_ctrl`

## Requirements
- R1: While running, a level greater than or equal to `trip_thr_i` makes `halt_o` go high on the next cycle.
- R2: `halt_o` stays high from the halt request through the end of restore. No store write and no register write occurs while `halt_o` is low.
- R3: The save starts on the cycle after `core_halted_i` is seen high. It issues `nv_we_o` for NREG consecutive cycles with `nv_addr_o` = `reg_idx_o` counting 0 to NREG-1, and `nv_wdata_o` carries the indexed core register.
- R4: `ckpt_valid_o` is cleared when a save begins. It is set only after the word at address NREG-1 has been written with `nv_err_i` low.
- R5: While parked, the restore starts only when `all_clear_i` is high or the level is below `clear_thr_i`, and the level is below `trip_thr_i`. A level between the two thresholds keeps the core halted.
- R6: A restore issues `reg_wr_en_o` for NREG consecutive cycles, with index and store address counting 0 to NREG-1 and `reg_wr_data_o` equal to `nv_rdata_i`. `nv_we_o` stays low throughout.
- R7: After the last restored word, `resume_o` is high for exactly one cycle with `halt_o` low, and the core's registers equal the values they held when saving.
- R8: A trip-level reading during restore suppresses that cycle's register write and returns the controller to the parked state. The store is not written, `ckpt_valid_o` stays set, and the next restore starts again from index 0.
- R9: `nv_err_i` high during a save cycle ends the save at once and leaves `ckpt_valid_o` low.
- R10: A clear condition with `ckpt_valid_o` low skips the restore (no register write). It sets `fault_o` and goes straight to the one-cycle resume. `fault_o` clears when the next save begins.
- R11: After reset, `halt_o`, `resume_o`, `nv_we_o`, `reg_wr_en_o`, `ckpt_valid_o` and `fault_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_i | input | LW | Sampled radiation level |
| trip_thr_i | input | LW | Level at or above which the core is stopped |
| clear_thr_i | input | LW | Level below which the hazard counts as gone |
| all_clear_i | input | 1 | External hazard-over indication |
| halt_o | output | 1 | Request for the core to stop and stay stopped |
| core_halted_i | input | 1 | Core confirms it has stopped |
| resume_o | output | 1 | One-cycle release of the core |
| reg_idx_o | output | IW | Core register index for read or load |
| reg_rd_data_i | input | DW | Value of the indexed core register |
| reg_wr_en_o | output | 1 | Load strobe for the indexed core register |
| reg_wr_data_o | output | DW | Value loaded into the core register |
| nv_we_o | output | 1 | Store write strobe |
| nv_addr_o | output | IW | Store word address |
| nv_wdata_o | output | DW | Store write data |
| nv_rdata_i | input | DW | Store read data for `nv_addr_o`, same cycle |
| nv_err_i | input | 1 | Store rejects the current write |
| ckpt_valid_o | output | 1 | A complete checkpoint is held in the store |
| fault_o | output | 1 | A restore was skipped for lack of a checkpoint |

## Verification
The bound assertions watch, on every cycle, that the halt request follows a trip reading, that no strobe fires while the core runs, that store writes step through consecutive addresses and never coincide with register loads, that a trip reading blocks a register load, and that the valid flag and fault only appear at the last saved word and at a skipped restore. Properties cannot show that the restored register values are the ones held at the suspension point, that an aborted restore leaves the stored image intact and restarts from index 0, or that a level between the thresholds holds the core parked indefinitely. The bench scenarios show these by corrupting the core registers while halted and comparing register and store contents afterwards, alongside a per-cycle reference model.

// File: rtl/rad_ckpt_pkg.sv
package rad_ckpt_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_HALT_REQ = 3'd1,
        ST_SAVE     = 3'd2,
        ST_WAIT_CLR = 3'd3,
        ST_RESTORE  = 3'd4,
        ST_RESUME   = 3'd5
    } ckpt_state_e;

    typedef struct packed {
        logic hazard;    // level at or above trip threshold
        logic clear_ok;  // external all-clear or level under lower threshold
    } lvl_flags_t;

    function automatic int idx_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rad_lvl_mon.sv
module rad_lvl_mon
    import rad_ckpt_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] trip_thr_i,
    input  logic [LW-1:0] clear_thr_i,
    input  logic          all_clear_i,
    output lvl_flags_t    flags_o
);
    always_comb begin
        flags_o.hazard   = (level_i >= trip_thr_i);
        flags_o.clear_ok = all_clear_i || (level_i < clear_thr_i);
    end
endmodule

// File: rtl/rad_idx_cnt.sv
module rad_idx_cnt #(
    parameter int NREG = 8,
    parameter int IW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [IW-1:0] idx_o,
    output logic          last_o
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NREG - 1);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            idx_o <= '0;
        else if (inc_i)
            idx_o <= idx_o + 1'b1;
    end

    assign last_o = (idx_o == LAST_IDX);
endmodule

// File: rtl/rad_ckpt_seq.sv
module rad_ckpt_seq
    import rad_ckpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lvl_flags_t  flags_i,
    input  logic        core_halted_i,
    input  logic        nv_err_i,
    input  logic        last_i,
    output ckpt_state_e state_o,
    output logic        cnt_clr_o,
    output logic        cnt_inc_o,
    output logic        valid_o,
    output logic        fault_o
);
    ckpt_state_e state_q, state_d;
    logic        valid_d, fault_d;

    always_comb begin
        state_d   = state_q;
        valid_d   = valid_o;
        fault_d   = fault_o;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (flags_i.hazard) state_d = ST_HALT_REQ;
            end
            ST_HALT_REQ: begin
                if (core_halted_i) begin
                    state_d   = ST_SAVE;
                    cnt_clr_o = 1'b1;
                    valid_d   = 1'b0;
                    fault_d   = 1'b0;
                end
            end
            ST_SAVE: begin
                if (nv_err_i) begin
                    state_d = ST_WAIT_CLR;
                end else if (last_i) begin
                    state_d = ST_WAIT_CLR;
                    valid_d = 1'b1;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            ST_WAIT_CLR: begin
                if (flags_i.clear_ok && !flags_i.hazard) begin
                    if (valid_o) begin
                        state_d   = ST_RESTORE;
                        cnt_clr_o = 1'b1;
                    end else begin
                        state_d = ST_RESUME;
                        fault_d = 1'b1;
                    end
                end
            end
            ST_RESTORE: begin
                if (flags_i.hazard)
                    state_d = ST_WAIT_CLR;
                else if (last_i)
                    state_d = ST_RESUME;
                else
                    cnt_inc_o = 1'b1;
            end
            ST_RESUME: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            valid_o <= 1'b0;
            fault_o <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_o <= valid_d;
            fault_o <= fault_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/rad_ckpt_ctrl.sv
module rad_ckpt_ctrl
    import rad_ckpt_pkg::*;
#(
    parameter int  NREG = 8,
    parameter int  DW   = 32,
    parameter int  LW   = 12,
    localparam int IW   = idx_w(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] trip_thr_i,
    input  logic [LW-1:0] clear_thr_i,
    input  logic          all_clear_i,
    output logic          halt_o,
    input  logic          core_halted_i,
    output logic          resume_o,
    output logic [IW-1:0] reg_idx_o,
    input  logic [DW-1:0] reg_rd_data_i,
    output logic          reg_wr_en_o,
    output logic [DW-1:0] reg_wr_data_o,
    output logic          nv_we_o,
    output logic [IW-1:0] nv_addr_o,
    output logic [DW-1:0] nv_wdata_o,
    input  logic [DW-1:0] nv_rdata_i,
    input  logic          nv_err_i,
    output logic          ckpt_valid_o,
    output logic          fault_o
);
    lvl_flags_t    flags;
    ckpt_state_e   state;
    logic          cnt_clr, cnt_inc, cnt_last;
    logic [IW-1:0] idx;

    rad_lvl_mon #(.LW(LW)) u_lvl (
        .level_i     (level_i),
        .trip_thr_i  (trip_thr_i),
        .clear_thr_i (clear_thr_i),
        .all_clear_i (all_clear_i),
        .flags_o     (flags)
    );

    rad_ckpt_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .flags_i       (flags),
        .core_halted_i (core_halted_i),
        .nv_err_i      (nv_err_i),
        .last_i        (cnt_last),
        .state_o       (state),
        .cnt_clr_o     (cnt_clr),
        .cnt_inc_o     (cnt_inc),
        .valid_o       (ckpt_valid_o),
        .fault_o       (fault_o)
    );

    rad_idx_cnt #(.NREG(NREG), .IW(IW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .idx_o  (idx),
        .last_o (cnt_last)
    );

    always_comb begin
        halt_o        = (state == ST_HALT_REQ) || (state == ST_SAVE) ||
                        (state == ST_WAIT_CLR) || (state == ST_RESTORE);
        resume_o      = (state == ST_RESUME);
        nv_we_o       = (state == ST_SAVE);
        reg_wr_en_o   = (state == ST_RESTORE) && !flags.hazard;
        reg_idx_o     = idx;
        nv_addr_o     = idx;
        nv_wdata_o    = reg_rd_data_i;
        reg_wr_data_o = nv_rdata_i;
    end
endmodule

// File: rtl/rad_ckpt_chk.sv
module rad_ckpt_chk #(
    parameter int NREG = 8,
    parameter int LW   = 12,
    parameter int IW   = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [LW-1:0] level_i,
    input logic [LW-1:0] trip_thr_i,
    input logic          halt_o,
    input logic          resume_o,
    input logic          nv_we_o,
    input logic [IW-1:0] nv_addr_o,
    input logic          reg_wr_en_o,
    input logic          ckpt_valid_o,
    input logic          fault_o
);
    localparam logic [IW-1:0] LAST_ADDR = IW'(NREG - 1);

    AST_TRIP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (!halt_o && !resume_o && level_i >= trip_thr_i) |=> halt_o); // R1

    AST_QUIET_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        !halt_o |-> (!nv_we_o && !reg_wr_en_o)); // R2

    AST_SAVE_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (nv_we_o && $past(nv_we_o)) |-> (nv_addr_o == $past(nv_addr_o) + 1'b1)); // R3

    AST_VALID_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(ckpt_valid_o) |-> ($past(nv_we_o) && $past(nv_addr_o) == LAST_ADDR)); // R4

    AST_NO_SAVE_LOAD_MIX: assert property (@(posedge clk) disable iff (rst)
        !(nv_we_o && reg_wr_en_o)); // R6

    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> (!halt_o && !reg_wr_en_o) ##1 !resume_o); // R7

    AST_NO_LOAD_ON_TRIP: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en_o |-> (level_i < trip_thr_i)); // R8

    AST_FAULT_AT_SKIP: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> (resume_o && !ckpt_valid_o)); // R10
endmodule

bind rad_ckpt_ctrl rad_ckpt_chk #(.NREG(NREG), .LW(LW), .IW(IW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .level_i      (level_i),
    .trip_thr_i   (trip_thr_i),
    .halt_o       (halt_o),
    .resume_o     (resume_o),
    .nv_we_o      (nv_we_o),
    .nv_addr_o    (nv_addr_o),
    .reg_wr_en_o  (reg_wr_en_o),
    .ckpt_valid_o (ckpt_valid_o),
    .fault_o      (fault_o)
);

// File: tb/rad_ckpt_ctrl_bench.sv
module rad_ckpt_ctrl_bench;
    localparam int NREG = 8;
    localparam int DW   = 32;
    localparam int LW   = 12;
    localparam int IW   = 3;
    localparam logic [LW-1:0] TRIP = 12'h800;
    localparam logic [LW-1:0] CLR  = 12'h400;
    localparam logic [LW-1:0] LOW  = 12'h100;
    localparam logic [LW-1:0] MID  = 12'h600;
    localparam logic [LW-1:0] HIGH = 12'h900;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] level_i = LOW;
    logic          all_clear_i = 1'b0;
    logic          core_halted_i = 1'b0;
    logic          nv_err_i = 1'b0;
    logic          halt_o, resume_o, reg_wr_en_o, nv_we_o, ckpt_valid_o, fault_o;
    logic [IW-1:0] reg_idx_o, nv_addr_o;
    logic [DW-1:0] reg_rd_data_i, reg_wr_data_o, nv_wdata_o, nv_rdata_i;

    logic [DW-1:0] core_regs [NREG];
    logic [DW-1:0] nv_mem    [NREG];
    logic [DW-1:0] snap      [NREG];

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // reference model state: 0 run,1 halt req,2 save,3 wait,4 restore,5 resume
    int mst = 0, mcnt = 0;
    bit mvalid = 0, mfault = 0;

    always #4 clk = ~clk;

    rad_ckpt_ctrl #(.NREG(NREG), .DW(DW), .LW(LW)) u_rad_ckpt_ctrl (
        .clk(clk), .rst(rst), .level_i(level_i), .trip_thr_i(TRIP),
        .clear_thr_i(CLR), .all_clear_i(all_clear_i), .halt_o(halt_o),
        .core_halted_i(core_halted_i), .resume_o(resume_o),
        .reg_idx_o(reg_idx_o), .reg_rd_data_i(reg_rd_data_i),
        .reg_wr_en_o(reg_wr_en_o), .reg_wr_data_o(reg_wr_data_o),
        .nv_we_o(nv_we_o), .nv_addr_o(nv_addr_o), .nv_wdata_o(nv_wdata_o),
        .nv_rdata_i(nv_rdata_i), .nv_err_i(nv_err_i),
        .ckpt_valid_o(ckpt_valid_o), .fault_o(fault_o)
    );

    assign reg_rd_data_i = core_regs[reg_idx_o];
    assign nv_rdata_i    = nv_mem[nv_addr_o];

    // environment: core register file, store, halt acknowledge
    always @(posedge clk) begin
        if (reg_wr_en_o) core_regs[reg_idx_o] <= reg_wr_data_o;
        if (nv_we_o && !nv_err_i) nv_mem[nv_addr_o] <= nv_wdata_o;
        core_halted_i <= halt_o;
    end

    // reference model update
    always @(posedge clk) begin
        bit haz, clr;
        haz = (level_i >= TRIP);
        clr = all_clear_i || (level_i < CLR);
        if (rst) begin
            mst = 0; mcnt = 0; mvalid = 0; mfault = 0;
        end else begin
            case (mst)
                0: if (haz) mst = 1;
                1: if (core_halted_i) begin mst = 2; mcnt = 0; mvalid = 0; mfault = 0; end
                2: if (nv_err_i) mst = 3;
                   else if (mcnt == NREG-1) begin mvalid = 1; mst = 3; end
                   else mcnt++;
                3: if (clr && !haz) begin
                       if (mvalid) begin mst = 4; mcnt = 0; end
                       else begin mfault = 1; mst = 5; end
                   end
                4: if (haz) mst = 3;
                   else if (mcnt == NREG-1) mst = 5;
                   else mcnt++;
                default: mst = 0;
            endcase
        end
        cycles++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            bit e_halt, e_we, e_rw, e_res;
            e_halt = (mst >= 1 && mst <= 4);
            e_we   = (mst == 2);
            e_rw   = (mst == 4) && (level_i < TRIP);
            e_res  = (mst == 5);
            chk(halt_o == e_halt, "R1/R2 halt_o", halt_o, e_halt);
            chk(nv_we_o == e_we, "R3 nv_we_o", nv_we_o, e_we);
            chk(reg_wr_en_o == e_rw, "R6/R8 reg_wr_en_o", reg_wr_en_o, e_rw);
            chk(resume_o == e_res, "R7 resume_o", resume_o, e_res);
            chk(ckpt_valid_o == mvalid, "R4 ckpt_valid_o", ckpt_valid_o, mvalid);
            chk(fault_o == mfault, "R10 fault_o", fault_o, mfault);
            if (e_we) begin
                chk(nv_addr_o == IW'(mcnt), "R3 nv_addr_o", nv_addr_o, mcnt);
                chk(nv_wdata_o == core_regs[mcnt], "R3 nv_wdata_o", nv_wdata_o, core_regs[mcnt]);
            end
            if (e_rw) begin
                chk(reg_idx_o == IW'(mcnt), "R6 reg_idx_o", reg_idx_o, mcnt);
                chk(reg_wr_data_o == nv_mem[mcnt], "R6 reg_wr_data_o", reg_wr_data_o, nv_mem[mcnt]);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_st(input int s);
        for (int k = 0; k < 200 && mst != s; k++) step(1);
        chk(mst == s, "sequence reached state", mst, s);
    endtask

    task automatic load_core(input logic [DW-1:0] seed);
        for (int i = 0; i < NREG; i++) begin
            core_regs[i] = seed ^ (32'h1111_0000 * i) ^ i;
            snap[i] = core_regs[i];
        end
    endtask

    task automatic trash_core();
        for (int i = 0; i < NREG; i++) core_regs[i] = 32'hDEAD_0000 | i;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) nv_mem[i] = '0;
        load_core(32'hA5A5_0001);
        step(3);
        // R11: reset state
        chk(!halt_o && !resume_o && !nv_we_o && !reg_wr_en_o, "R11 strobes in reset", halt_o, 0);
        chk(!ckpt_valid_o && !fault_o, "R11 flags in reset", ckpt_valid_o, 0);
        rst = 1'b0;
        step(4);

        // R1/R3/R4: trip and save
        level_i = HIGH;
        step(1);
        chk(halt_o == 1'b1, "R1 halt after trip", halt_o, 1);
        wait_st(3);
        for (int i = 0; i < NREG; i++)
            chk(nv_mem[i] == snap[i], "R3 saved word", nv_mem[i], snap[i]);
        chk(ckpt_valid_o == 1'b1, "R4 valid after save", ckpt_valid_o, 1);

        // R5: hysteresis band keeps core parked
        trash_core();
        level_i = MID;
        step(12);
        chk(halt_o == 1'b1 && mst == 3, "R5 mid level stays halted", halt_o, 1);
        all_clear_i = 1'b1; level_i = HIGH;
        step(5);
        chk(halt_o == 1'b1 && !reg_wr_en_o, "R5 all-clear ignored under trip", reg_wr_en_o, 0);
        all_clear_i = 1'b0;

        // R6/R7: clear by low level, restore, resume
        level_i = LOW;
        wait_st(5);
        wait_st(0);
        for (int i = 0; i < NREG; i++)
            chk(core_regs[i] == snap[i], "R7 register restored", core_regs[i], snap[i]);

        // R8: abort during restore, then restore via all-clear
        load_core(32'h3C3C_0777);
        step(3);
        level_i = HIGH;
        wait_st(3);
        trash_core();
        level_i = MID; all_clear_i = 1'b1;
        wait_st(4);
        all_clear_i = 1'b0;
        step(3);
        level_i = HIGH;
        step(1);
        chk(mst == 3 && halt_o, "R8 abort returns to wait", mst, 3);
        chk(ckpt_valid_o == 1'b1, "R8 checkpoint kept", ckpt_valid_o, 1);
        for (int i = 0; i < NREG; i++)
            chk(nv_mem[i] == snap[i], "R8 store untouched", nv_mem[i], snap[i]);
        step(4);
        level_i = LOW;
        wait_st(5);
        wait_st(0);
        for (int i = 0; i < NREG; i++)
            chk(core_regs[i] == snap[i], "R8 full restore after abort", core_regs[i], snap[i]);

        // R9/R10: store error, skipped restore, fault
        load_core(32'h0F0F_1234);
        step(2);
        level_i = HIGH;
        wait_st(2);
        step(2);
        nv_err_i = 1'b1;
        step(1);
        nv_err_i = 1'b0;
        chk(mst == 3 && ckpt_valid_o == 1'b0, "R9 save ended by error", ckpt_valid_o, 0);
        trash_core();
        for (int i = 0; i < NREG; i++) snap[i] = core_regs[i];
        level_i = LOW;
        step(1);
        chk(resume_o == 1'b1 && fault_o == 1'b1, "R10 fault and direct resume", fault_o, 1);
        step(2);
        for (int i = 0; i < NREG; i++)
            chk(core_regs[i] == snap[i], "R10 no register load", core_regs[i], snap[i]);

        // R10: fault clears when next save begins
        level_i = HIGH;
        wait_st(2);
        chk(fault_o == 1'b0, "R10 fault cleared at save", fault_o, 0);
        wait_st(3);
        level_i = LOW;
        wait_st(0);
        step(3);
        summary();
    end

    initial begin
        wait (cycles > 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        summary();
    end
endmodule